// File: doc/BRIEF.md
# Normal-Basis Field Inverter (Addition-Chain Sequencer)

This block computes the multiplicative inverse of an element of GF(2^N). Elements are held in a type-1 optimal normal basis, so squaring is a one-bit rotation and the only costly step is a full field product. The inverse is obtained as the square of a^(2^(N-1)-1). That power is built by an addition chain that walks the bits of the exponent N-1 from the top down. At each step the running power is doubled in length with one rotation and one multiply. When the current exponent bit is one, a one-bit rotation and a second multiply by the original operand are added.

A caller places the element on `operand` and pulses `start`. Some cycles later `done` pulses for one cycle and `result` holds the inverse. `result` keeps that value until the next run finishes. A new `start` is honoured only while the block is idle. The field products go to a bit-serial normal-basis multiplier inside the block, which produces one coefficient per cycle. Rotations by a variable amount pass through a logarithmic rotator and take one cycle.

Top module: `gf2n_nb_inverter`

## Requirements
- R1: After reset, `done` is 0 and `result` is all zeros.
- R2: For a nonzero `operand` a, `result` is the element b with a*b equal to the unit element, which is all ones. Bit i of a word is the coefficient of beta^(2^i). beta is a primitive (N+1)-th root of unity. The product of basis terms i and j is beta^((2^i+2^j) mod (N+1)), and exponent 0 stands for the all-ones word.
- R3: A zero `operand` yields a zero `result`, with `done` still pulsed after the normal latency.
- R4: `done` is high for exactly one cycle. It rises exactly M*(N+3)+1 clock edges after the edge that samples `start`, where M is the number of field multiplies of R5.
- R5: One inversion uses M = floor(log2(N-1)) + popcount(N-1) - 1 field multiplies.
- R6: A `start` pulse that arrives while an inversion is running is ignored. The running result is unchanged, and no extra `done` follows.
- R7: `result` changes only in a cycle where `done` is high, and otherwise holds its value.
- R8: Each field multiply is issued only to an idle multiplier and delivers its product exactly N clock edges after the issue edge, so it occupies N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an inversion of `operand` (sampled when idle) |
| operand | input | N | Field element to invert, normal-basis coefficients |
| result | output | N | Inverse of the last accepted operand |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
On every cycle, the checker enforces the following: the one-cycle `done` pulse, the exact run latency and multiply count, the multiplier's issue rule and its N-edge delay, and that `result` moves only together with `done`. It also checks that a zero operand gives a zero result and that a nonzero operand gives a nonzero one. Only the bench scenarios can show that every nonzero element of the field really comes back with its inverse. That is judged by a product taken in an independent exponent-based arithmetic. The bench scenarios also show that a start pulse arriving mid-run leaves the answer and the pulse count untouched.

// File: rtl/nb_inv_pkg.sv
package nb_inv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROT, ST_MGO1, ST_MW1, ST_SQ, ST_MGO2, ST_MW2, ST_FIN
  } inv_state_t;

  // 2^e mod m with a bounded loop
  function automatic int pow2_mod(input int e, input int m);
    int r;
    r = 1 % m;
    for (int i = 0; i < 64; i++) begin
      if (i < e) r = (r * 2) % m;
    end
    return r;
  endfunction

  // coefficient of beta in beta^(2^i) * beta^(2^j), type-1 normal basis
  function automatic bit onb1_lambda(input int n, input int i, input int j);
    int s;
    s = (pow2_mod(i, n + 1) + pow2_mod(j, n + 1)) % (n + 1);
    return (s == 1) || (s == 0);
  endfunction

  function automatic int floor_log2(input int v);
    int r;
    r = 0;
    for (int b = 0; b < 31; b++) begin
      if ((v >> b) != 0) r = b;
    end
    return r;
  endfunction

  function automatic int popcount(input int v);
    int c;
    c = 0;
    for (int b = 0; b < 31; b++) c += (v >> b) & 1;
    return c;
  endfunction

  function automatic int inv_mul_count(input int n);
    return floor_log2(n - 1) + popcount(n - 1) - 1;
  endfunction

  function automatic int inv_latency(input int n);
    return inv_mul_count(n) * (n + 3) + 1;
  endfunction

endpackage

// File: rtl/nb_rotl.sv
module nb_rotl #(
  parameter int W  = 10,
  parameter int AW = 4
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:AW];
  assign stg[0] = din;

  for (genvar b = 0; b < AW; b++) begin : g_stage
    localparam int SH = (2 ** b) % W;
    if (SH == 0) begin : g_noshift
      assign stg[b+1] = stg[b];
    end else begin : g_shift
      assign stg[b+1] = amt[b] ? {stg[b][W-1-SH:0], stg[b][W-1:W-SH]} : stg[b];
    end
  end

  assign dout = stg[AW];
endmodule

// File: rtl/nb_serial_mul.sv
module nb_serial_mul
  import nb_inv_pkg::*;
#(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  output logic         busy,
  output logic         fin,
  output logic [N-1:0] prod
);
  localparam int CW = $clog2(N);

  function automatic logic [N*N-1:0] build_lam();
    logic [N*N-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        v[i*N+j] = onb1_lambda(N, i, j);
    return v;
  endfunction

  localparam logic [N*N-1:0] LAM = build_lam();

  logic [N-1:0]  ra, rb;
  logic [CW-1:0] cnt;
  logic          cbit;

  // one product coefficient from the current rotated operands
  always_comb begin
    cbit = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        cbit = cbit ^ (LAM[i*N+j] & ra[i] & rb[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      cnt  <= '0;
      ra   <= '0;
      rb   <= '0;
      prod <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        ra   <= opa;
        rb   <= opb;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        prod[cnt] <= cbit;
        ra <= {ra[0], ra[N-1:1]};
        rb <= {rb[0], rb[N-1:1]};
        if (cnt == CW'(N - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nb_inv_seq.sv
module nb_inv_seq
  import nb_inv_pkg::*;
#(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] operand,
  output logic [N-1:0] result,
  output logic         done,
  output logic         busy,
  output logic         accept,
  output logic         mul_go,
  output logic [N-1:0] mul_opa,
  output logic [N-1:0] mul_opb,
  input  logic         mul_fin,
  input  logic [N-1:0] mul_prod
);
  localparam int EW = $clog2(N) + 1;
  localparam int AW = $clog2(N);
  localparam logic [EW-1:0] E_VEC = EW'(N - 1);
  localparam int S0 = floor_log2(N - 1) - 1;

  inv_state_t    state;
  logic [N-1:0]  k_r, p_r, q_r, t_r;
  logic [EW-1:0] s_r;
  logic [EW-1:0] m_full;
  logic [N-1:0]  q_next;
  logic          chain_bit;
  logic          last_step;

  assign m_full    = E_VEC >> (s_r + 1'b1);
  assign chain_bit = E_VEC[s_r];
  assign last_step = (s_r == '0);

  nb_rotl #(.W(N), .AW(AW)) u_qrot (
    .din  (p_r),
    .amt  (m_full[AW-1:0]),
    .dout (q_next)
  );

  assign busy    = (state != ST_IDLE);
  assign accept  = (state == ST_IDLE) && start;
  assign mul_go  = (state == ST_MGO1) || (state == ST_MGO2);
  assign mul_opa = (state == ST_MGO2) ? t_r : p_r;
  assign mul_opb = (state == ST_MGO2) ? k_r : q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      k_r    <= '0;
      p_r    <= '0;
      q_r    <= '0;
      t_r    <= '0;
      s_r    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          k_r   <= operand;
          p_r   <= operand;
          s_r   <= EW'(S0);
          state <= ST_ROT;
        end
        ST_ROT: begin
          q_r   <= q_next;
          state <= ST_MGO1;
        end
        ST_MGO1: state <= ST_MW1;
        ST_MW1: if (mul_fin) begin
          if (chain_bit) begin
            t_r   <= mul_prod;
            state <= ST_SQ;
          end else begin
            p_r <= mul_prod;
            if (last_step) state <= ST_FIN;
            else begin
              s_r   <= s_r - 1'b1;
              state <= ST_ROT;
            end
          end
        end
        ST_SQ: begin
          t_r   <= {t_r[N-2:0], t_r[N-1]};
          state <= ST_MGO2;
        end
        ST_MGO2: state <= ST_MW2;
        ST_MW2: if (mul_fin) begin
          p_r <= mul_prod;
          if (last_step) state <= ST_FIN;
          else begin
            s_r   <= s_r - 1'b1;
            state <= ST_ROT;
          end
        end
        ST_FIN: begin
          result <= {p_r[N-2:0], p_r[N-1]};
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf2n_nb_inverter.sv
module gf2n_nb_inverter #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] operand,
  output logic [N-1:0] result,
  output logic         done
);
  logic         seq_busy;
  logic         seq_accept;
  logic         mul_go;
  logic         mul_busy;
  logic         mul_fin;
  logic [N-1:0] mul_opa, mul_opb, mul_prod;

  nb_inv_seq #(.N(N)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .operand  (operand),
    .result   (result),
    .done     (done),
    .busy     (seq_busy),
    .accept   (seq_accept),
    .mul_go   (mul_go),
    .mul_opa  (mul_opa),
    .mul_opb  (mul_opb),
    .mul_fin  (mul_fin),
    .mul_prod (mul_prod)
  );

  nb_serial_mul #(.N(N)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (mul_go),
    .opa   (mul_opa),
    .opb   (mul_opb),
    .busy  (mul_busy),
    .fin   (mul_fin),
    .prod  (mul_prod)
  );
endmodule

// File: rtl/nb_inv_checker.sv
module nb_inv_checker
  import nb_inv_pkg::*;
#(
  parameter int N = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [N-1:0] operand,
  input logic [N-1:0] result,
  input logic         done,
  input logic         busy,
  input logic         accept,
  input logic         mul_go,
  input logic         mul_busy,
  input logic         mul_fin
);
  localparam int MULS = inv_mul_count(N);
  localparam int LAT  = inv_latency(N);

  logic [15:0] run_cyc, mul_cyc, go_cnt;
  logic        zero_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cyc <= '0;
      mul_cyc <= '0;
      go_cnt  <= '0;
      zero_in <= 1'b0;
    end else begin
      if (accept) begin
        run_cyc <= '0;
        go_cnt  <= '0;
        zero_in <= (operand == '0);
      end else begin
        if (busy) run_cyc <= run_cyc + 1'b1;
        if (mul_go) go_cnt <= go_cnt + 1'b1;
      end
      if (mul_go) mul_cyc <= '0;
      else if (mul_busy) mul_cyc <= mul_cyc + 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cyc == 16'(LAT))); // R4
  AST_MUL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (go_cnt == 16'(MULS))); // R5
  AST_MUL_ISSUE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |-> !mul_busy); // R8
  AST_MUL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fin |-> (mul_cyc == 16'(N))); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done); // R7
  AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_in) |-> (result == '0)); // R3
  AST_NONZERO_MAPS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !zero_in) |-> (result != '0)); // R2
endmodule

bind gf2n_nb_inverter nb_inv_checker #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .operand  (operand),
  .result   (result),
  .done     (done),
  .busy     (seq_busy),
  .accept   (seq_accept),
  .mul_go   (mul_go),
  .mul_busy (mul_busy),
  .mul_fin  (mul_fin)
);

// File: tb/test_gf2n_nb_inverter.sv
`timescale 1ns/1ps
module test_gf2n_nb_inverter;
  localparam int N = 10;
  localparam logic [N-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] operand = '0;
  logic [N-1:0] result;
  logic         done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int p2 [0:N-1];
  int idx [0:N];

  always #5 clk = ~clk;

  gf2n_nb_inverter #(.N(N)) i_gf2n_nb_inverter (
    .clk(clk), .rst_n(rst_n), .start(start),
    .operand(operand), .result(result), .done(done)
  );

  // product via exponents of the (N+1)-th root of unity
  function automatic logic [N-1:0] bmul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] acc;
    int e;
    acc = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (a[i] && b[j]) begin
          e = (p2[i] + p2[j]) % (N + 1);
          if (e == 0) acc = acc ^ ONES;
          else acc[idx[e]] = ~acc[idx[e]];
        end
    return acc;
  endfunction

  function automatic int exp_muls();
    int v, top, ones;
    v = N - 1; top = 0; ones = 0;
    while ((v >> (top + 1)) != 0) top++;
    for (int b = 0; b <= top; b++) ones += (v >> b) & 1;
    return top + ones - 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_inv(input logic [N-1:0] a, output logic [N-1:0] r, output int cyc);
    @(negedge clk);
    operand = a;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    r = result;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(2_000_000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] r, r0;
    int cyc, lat, m, extra;
    for (int i = 0; i < N; i++) begin
      p2[i] = 1;
      for (int k = 0; k < i; k++) p2[i] = (p2[i] * 2) % (N + 1);
      idx[p2[i]] = i;
    end
    m = exp_muls();
    lat = m * (N + 3) + 1;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(result == '0, "R1 result", int'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 zero operand
    run_inv('0, r, cyc);
    check(done == 1'b1, "R3 done", int'(done), 1);
    check(r == '0, "R3 result", int'(r), 0);
    check(cyc == lat, "R3 latency", cyc, lat);

    // R2 R4 R5 sweep of every nonzero element
    for (int a = 1; a < (1 << N); a++) begin
      run_inv(N'(a), r, cyc);
      check(bmul(N'(a), r) == ONES, "R2 inverse", int'(r), a);
      check(cyc == lat, "R4 latency", cyc, lat);
      if (a < 4) check(((cyc - 1) / (N + 3)) == m && ((cyc - 1) % (N + 3)) == 0,
                       "R5 multiply count", (cyc - 1) / (N + 3), m);
      @(negedge clk);
      check(done == 1'b0, "R4 pulse width", int'(done), 0);
    end

    // R7 result holds while idle
    r0 = result;
    repeat (20) @(negedge clk);
    check(result == r0, "R7 hold", int'(result), int'(r0));

    // R6 start during a run is ignored
    @(negedge clk);
    operand = 10'h2A5;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    operand = 10'h013;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 6;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    check(cyc == lat, "R6 latency", cyc, lat);
    check(bmul(10'h2A5, result) == ONES, "R6 result", int'(result), 'h2A5);
    r0 = result;
    extra = 0;
    for (int c = 0; c < lat + 5; c++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R6 no extra done", extra, 0);
    check(result == r0, "R7 hold after ignored start", int'(result), int'(r0));

    finish_run();
  end
endmodule